// File: doc/BRIEF.md
# Video Border Frame Overlay Generator

This block draws rectangular border lines over a digital luma/chroma (Y, I, Q) video stream. A display timing source supplies a pixel counter and a line counter for every sample. Up to five horizontal lines and up to five vertical lines can each be placed anywhere on the raster. Each line can be switched on or off by itself. When any enabled line covers the current pixel, the incoming samples are replaced with programmable frame levels. All other samples pass through unchanged.

Each horizontal line is placed at a 10-bit line number. It is drawn over every pixel of the lines from that position to the position plus the horizontal-line thickness. Each vertical line is placed at a 10-bit pixel number. It is drawn over every line, across the pixels from that position to the position plus the vertical-line thickness. A single window outline, such as the one needed for a picture-in-picture display, is formed by lines 1 and 5 in each direction. The frame colour has an 8-bit luma level and 4-bit I and Q levels. Every output, including the frame-active flag, is registered and appears one clock after its inputs.

Top module: `frame_overlay`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge sets `y_out`, `i_out` and `q_out` to 0 and sets `frame_act` to 0.
- R2: Horizontal line k (k = 0..4, position field bits [10k+9:10k] of `hline_pos`) with `hline_en_n[k]` = 0 frames every pixel whose line counter `v_cnt` satisfies pos <= v_cnt <= pos + `h_thick`, whatever the value of `h_cnt`.
- R3: Vertical line k (position field bits [10k+9:10k] of `vline_pos`) with `vline_en_n[k]` = 0 frames every pixel whose pixel counter `h_cnt` satisfies pos <= h_cnt <= pos + `v_thick`, whatever the value of `v_cnt`.
- R4: A line whose enable bit is 1 has no effect: when all ten enable bits are 1, no pixel is framed, and every output equals its input delayed by one clock.
- R5: For a framed pixel, `y_out` equals `lvl_y`, `i_out` equals {`lvl_i`, 4'b0000}, `q_out` equals {`lvl_q`, 4'b0000}, and `frame_act` is 1.
- R6: For a pixel that is not framed, `y_out`, `i_out` and `q_out` equal `y_in`, `i_in` and `q_in`, and `frame_act` is 0.
- R7: Outputs change only at a rising clock edge. They reflect the inputs present at the edge immediately before: the latency is exactly one clock.
- R8: The end of a line's span is computed without wrap-around. A line placed near the top of the 10-bit range does not frame pixels with small counter values.
- R9: Enabled lines combine by OR: a pixel is framed when at least one enabled line, horizontal or vertical, covers it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_cnt | input | 10 | Pixel counter of the current sample |
| v_cnt | input | 10 | Line counter of the current sample |
| y_in | input | 8 | Incoming luma sample |
| i_in | input | 8 | Incoming I chroma sample |
| q_in | input | 8 | Incoming Q chroma sample |
| hline_pos | input | 50 | Five 10-bit line positions of the horizontal lines, line k at bits [10k+9:10k] |
| hline_en_n | input | 5 | Horizontal line enables, 0 = line drawn |
| vline_pos | input | 50 | Five 10-bit pixel positions of the vertical lines, line k at bits [10k+9:10k] |
| vline_en_n | input | 5 | Vertical line enables, 0 = line drawn |
| h_thick | input | 4 | Extra lines covered by each horizontal line |
| v_thick | input | 4 | Extra pixels covered by each vertical line |
| lvl_y | input | 8 | Frame luma level |
| lvl_i | input | 4 | Frame I level, placed in the upper nibble |
| lvl_q | input | 4 | Frame Q level, placed in the upper nibble |
| y_out | output | 8 | Output luma sample |
| i_out | output | 8 | Output I chroma sample |
| q_out | output | 8 | Output Q chroma sample |
| frame_act | output | 1 | High while the output sample is a frame sample |

## Verification
Every result of this block is due at the first rising edge after its inputs are presented. The bench therefore changes the counters, samples and settings at a falling edge and samples the outputs 5 ns after the next rising edge. At that point it compares them with a frame decision computed from the same values, using integer arithmetic that cannot wrap. A dedicated latency check looks at the outputs just before that rising edge and confirms they still show the previous sample. A second look just after the edge confirms the new one. The sweeps cover the counter ranges around every line start and end, with zero, mid and maximum thickness, and include the top of the 10-bit range.

// File: rtl/frame_overlay_pkg.sv
// Shared widths and the sample type of the border frame overlay.
// Assumes 8-bit luma and chroma samples and 4-bit chroma frame levels.
package frame_overlay_pkg;
    localparam int unsigned SMP_W = 8;
    localparam int unsigned LVL_W = 4;
    localparam int unsigned PAD_W = SMP_W - LVL_W;

    typedef struct packed {
        logic [SMP_W-1:0] y;
        logic [SMP_W-1:0] i;
        logic [SMP_W-1:0] q;
    } yiq_t;
endpackage

// File: rtl/frame_line_match.sv
// Tests whether one counter lies inside the span of one frame line.
// The span runs from pos to pos+thk inclusive. Its end is computed one
// bit wider than the counter, so it never wraps. Purely combinational.
module frame_line_match #(
    parameter int unsigned POS_W = 10,
    parameter int unsigned THK_W = 4
) (
    input  logic [POS_W-1:0] cnt,
    input  logic [POS_W-1:0] pos,
    input  logic [THK_W-1:0] thk,
    input  logic             en_n,
    output logic             hit
);
    localparam int unsigned EXT_W = POS_W + 1;

    logic [EXT_W-1:0] span_end;

    // Widened end of span and inclusive range test
    always_comb begin
        span_end = {1'b0, pos} + {{(EXT_W-THK_W){1'b0}}, thk};
        hit      = !en_n && (cnt >= pos) && ({1'b0, cnt} <= span_end);
    end
endmodule

// File: rtl/frame_axis_detect.sv
// Evaluates all lines of one direction against one counter and ORs the
// results. Assumes the positions are packed, line k at [k*POS_W +: POS_W].
module frame_axis_detect #(
    parameter int unsigned NUM_LINES = 5,
    parameter int unsigned POS_W     = 10,
    parameter int unsigned THK_W     = 4
) (
    input  logic [POS_W-1:0]           cnt,
    input  logic [NUM_LINES*POS_W-1:0] pos_bus,
    input  logic [NUM_LINES-1:0]       en_n,
    input  logic [THK_W-1:0]           thk,
    output logic                       any_hit
);
    logic [NUM_LINES-1:0] line_hit;

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        frame_line_match #(
            .POS_W (POS_W),
            .THK_W (THK_W)
        ) u_match (
            .cnt  (cnt),
            .pos  (pos_bus[k*POS_W +: POS_W]),
            .thk  (thk),
            .en_n (en_n[k]),
            .hit  (line_hit[k])
        );
    end

    // Any covering line frames the pixel
    always_comb any_hit = |line_hit;
endmodule

// File: rtl/frame_mixer.sv
// Registered substitution stage. It replaces the sample with the frame
// levels when frame_hit is high and otherwise passes the sample through.
// The chroma levels fill the upper nibble and the lower bits are zero.
// Assumes frame_hit is aligned with the sample on its inputs.
module frame_mixer
    import frame_overlay_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_hit,
    input  yiq_t             smp_in,
    input  logic [SMP_W-1:0] lvl_y,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic [LVL_W-1:0] lvl_q,
    output yiq_t             smp_out,
    output logic             frame_act
);
    yiq_t frame_smp;

    // Frame colour assembled into a full sample
    always_comb begin
        frame_smp.y = lvl_y;
        frame_smp.i = {lvl_i, {PAD_W{1'b0}}};
        frame_smp.q = {lvl_q, {PAD_W{1'b0}}};
    end

    // One-cycle output register with frame priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_out   <= '0;
            frame_act <= 1'b0;
        end else begin
            smp_out   <= frame_hit ? frame_smp : smp_in;
            frame_act <= frame_hit;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (smp_out == '0 && !frame_act));

    // R5
    frame_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_act |-> (smp_out.y == $past(lvl_y)
                       && smp_out.i[SMP_W-1 -: LVL_W] == $past(lvl_i)
                       && smp_out.q[SMP_W-1 -: LVL_W] == $past(lvl_q)
                       && smp_out.i[PAD_W-1:0] == '0
                       && smp_out.q[PAD_W-1:0] == '0));

    // R6
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_act && $past(rst_n)) |-> (smp_out == $past(smp_in)));
endmodule

// File: rtl/frame_overlay.sv
// Border frame overlay top. Horizontal lines are matched against the line
// counter and vertical lines against the pixel counter. The two results
// are ORed and the sample is substituted one clock later.
// Assumes the counters are aligned with the samples they accompany.
module frame_overlay
    import frame_overlay_pkg::*;
#(
    parameter int unsigned NUM_LINES = 5,
    parameter int unsigned POS_W     = 10,
    parameter int unsigned THK_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [POS_W-1:0]           h_cnt,
    input  logic [POS_W-1:0]           v_cnt,
    input  logic [SMP_W-1:0]           y_in,
    input  logic [SMP_W-1:0]           i_in,
    input  logic [SMP_W-1:0]           q_in,
    input  logic [NUM_LINES*POS_W-1:0] hline_pos,
    input  logic [NUM_LINES-1:0]       hline_en_n,
    input  logic [NUM_LINES*POS_W-1:0] vline_pos,
    input  logic [NUM_LINES-1:0]       vline_en_n,
    input  logic [THK_W-1:0]           h_thick,
    input  logic [THK_W-1:0]           v_thick,
    input  logic [SMP_W-1:0]           lvl_y,
    input  logic [LVL_W-1:0]           lvl_i,
    input  logic [LVL_W-1:0]           lvl_q,
    output logic [SMP_W-1:0]           y_out,
    output logic [SMP_W-1:0]           i_out,
    output logic [SMP_W-1:0]           q_out,
    output logic                       frame_act
);
    logic h_hit;
    logic v_hit;
    logic px_hit;
    yiq_t smp_in;
    yiq_t smp_out;

    // Horizontal lines sit at line numbers
    frame_axis_detect #(
        .NUM_LINES (NUM_LINES),
        .POS_W     (POS_W),
        .THK_W     (THK_W)
    ) u_hlines (
        .cnt     (v_cnt),
        .pos_bus (hline_pos),
        .en_n    (hline_en_n),
        .thk     (h_thick),
        .any_hit (h_hit)
    );

    // Vertical lines sit at pixel numbers
    frame_axis_detect #(
        .NUM_LINES (NUM_LINES),
        .POS_W     (POS_W),
        .THK_W     (THK_W)
    ) u_vlines (
        .cnt     (h_cnt),
        .pos_bus (vline_pos),
        .en_n    (vline_en_n),
        .thk     (v_thick),
        .any_hit (v_hit)
    );

    // Combine directions and pack the incoming sample
    always_comb begin
        px_hit   = h_hit | v_hit;
        smp_in.y = y_in;
        smp_in.i = i_in;
        smp_in.q = q_in;
    end

    frame_mixer u_mixer (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_hit (px_hit),
        .smp_in    (smp_in),
        .lvl_y     (lvl_y),
        .lvl_i     (lvl_i),
        .lvl_q     (lvl_q),
        .smp_out   (smp_out),
        .frame_act (frame_act)
    );

    // Unpack the registered sample
    always_comb begin
        y_out = smp_out.y;
        i_out = smp_out.i;
        q_out = smp_out.q;
    end

    // R7
    one_cycle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (frame_act == $past(h_hit || v_hit)));

    // R4
    all_off_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&hline_en_n && &vline_en_n) |=> !frame_act);
endmodule

// File: tb/frame_overlay_tb.sv
module frame_overlay_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  h_cnt = '0, v_cnt = '0;
    logic [7:0]  y_in = '0, i_in = '0, q_in = '0;
    logic [49:0] hline_pos, vline_pos;
    logic [4:0]  hline_en_n = '1, vline_en_n = '1;
    logic [3:0]  h_thick = '0, v_thick = '0;
    logic [7:0]  lvl_y = '0;
    logic [3:0]  lvl_i = '0, lvl_q = '0;
    logic [7:0]  y_out, i_out, q_out;
    logic        frame_act;

    logic [9:0]  hp [5];
    logic [9:0]  vp [5];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 5; k++) begin
            hline_pos[k*10 +: 10] = hp[k];
            vline_pos[k*10 +: 10] = vp[k];
        end
    end

    frame_overlay u_dut (
        .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
        .y_in(y_in), .i_in(i_in), .q_in(q_in),
        .hline_pos(hline_pos), .hline_en_n(hline_en_n),
        .vline_pos(vline_pos), .vline_en_n(vline_en_n),
        .h_thick(h_thick), .v_thick(v_thick),
        .lvl_y(lvl_y), .lvl_i(lvl_i), .lvl_q(lvl_q),
        .y_out(y_out), .i_out(i_out), .q_out(q_out), .frame_act(frame_act)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (h=%0d v=%0d)", tag, act, exp, h_cnt, v_cnt);
        end
    endtask

    // Model of the frame decision, in integer arithmetic without wrap
    function automatic bit model_hit(int h, int v);
        bit f = 1'b0;
        for (int k = 0; k < 5; k++) begin
            if (!hline_en_n[k] && v >= int'(hp[k]) && v <= int'(hp[k]) + int'(h_thick)) f = 1'b1;
            if (!vline_en_n[k] && h >= int'(vp[k]) && h <= int'(vp[k]) + int'(v_thick)) f = 1'b1;
        end
        return f;
    endfunction

    // Drive one sample, then check the registered result after the next edge
    task automatic step(string tag, int h, int v);
        bit f;
        @(negedge clk);
        h_cnt = 10'(h);
        v_cnt = 10'(v);
        y_in  = 8'(h * 7 + v * 3 + 1);
        i_in  = 8'(h ^ (v << 2));
        q_in  = 8'(255 - h - v);
        f = model_hit(h, v);
        @(posedge clk);
        #5;
        chk(tag, int'(frame_act), int'(f));
        if (f) begin
            chk("R5 y", int'(y_out), int'(lvl_y));
            chk("R5 i", int'(i_out), int'({lvl_i, 4'b0000}));
            chk("R5 q", int'(q_out), int'({lvl_q, 4'b0000}));
        end else begin
            chk("R6 y", int'(y_out), int'(y_in));
            chk("R6 i", int'(i_out), int'(i_in));
            chk("R6 q", int'(q_out), int'(q_in));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 5; k++) begin hp[k] = '0; vp[k] = '0; end
        y_in = 8'hA5; i_in = 8'h5A; q_in = 8'h3C;
        hline_en_n = 5'b00000;
        repeat (3) @(posedge clk);
        #5;
        // R1: reset clears the outputs even with framing inputs active
        chk("R1 y", int'(y_out), 0);
        chk("R1 i", int'(i_out), 0);
        chk("R1 q", int'(q_out), 0);
        chk("R1 act", int'(frame_act), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: horizontal lines 1 and 5 only
        hline_en_n = 5'b01110; vline_en_n = 5'b11111;
        hp[0] = 10'd5; hp[4] = 10'd30; h_thick = 4'd2;
        hp[1] = 10'd12; hp[2] = 10'd18; hp[3] = 10'd24;
        lvl_y = 8'hEB; lvl_i = 4'h9; lvl_q = 4'h6;
        for (int v = 0; v <= 40; v++)
            for (int h = 0; h < 6; h++) step("R2", h * 97, v);

        // R3: vertical lines, thickness 0 then maximum
        hline_en_n = 5'b11111; vline_en_n = 5'b11100;
        vp[0] = 10'd3; vp[1] = 10'd20; vp[2] = 10'd500;
        lvl_y = 8'h10; lvl_i = 4'hF; lvl_q = 4'h1;
        for (int t = 0; t < 2; t++) begin
            v_thick = (t == 0) ? 4'd0 : 4'd15;
            for (int h = 0; h <= 40; h++)
                for (int v = 0; v < 3; v++) step("R3", h, v * 301);
        end

        // R4: every line disabled while positions cover the swept area
        hline_en_n = 5'b11111; vline_en_n = 5'b11111;
        for (int k = 0; k < 5; k++) begin hp[k] = 10'(k * 8); vp[k] = 10'(k * 8); end
        h_thick = 4'd15; v_thick = 4'd15;
        for (int v = 0; v <= 40; v += 2)
            for (int h = 0; h <= 40; h += 2) step("R4", h, v);

        // R9: all ten lines enabled, overlapping spans
        hline_en_n = 5'b00000; vline_en_n = 5'b00000;
        hp[0] = 10'd2; hp[1] = 10'd9; hp[2] = 10'd11; hp[3] = 10'd25; hp[4] = 10'd36;
        vp[0] = 10'd1; vp[1] = 10'd14; vp[2] = 10'd15; vp[3] = 10'd28; vp[4] = 10'd38;
        h_thick = 4'd1; v_thick = 4'd3;
        lvl_y = 8'h80; lvl_i = 4'h7; lvl_q = 4'h8;
        for (int v = 0; v <= 40; v++)
            for (int h = 0; h <= 40; h++) step("R9", h, v);

        // R8: lines near the top of the range must not wrap to low counts
        hline_en_n = 5'b11110; vline_en_n = 5'b11110;
        hp[0] = 10'd1020; vp[0] = 10'd1015; h_thick = 4'd15; v_thick = 4'd15;
        for (int c = 1000; c <= 1023; c++) begin
            step("R8", 500, c);
            step("R8", c, 500);
        end
        for (int c = 0; c <= 15; c++) begin
            step("R8", 500, c);
            step("R8", c, 500);
        end

        // R7: the output changes only at the edge after the stimulus
        hline_en_n = 5'b11110; vline_en_n = 5'b11111;
        hp[0] = 10'd100; h_thick = 4'd0;
        step("R7 setup", 0, 0);
        @(negedge clk);
        v_cnt = 10'd100;
        #5;
        chk("R7 before edge", int'(frame_act), 0);
        @(posedge clk);
        #5;
        chk("R7 after edge", int'(frame_act), 1);
        chk("R7 level", int'(y_out), int'(lvl_y));

        finish_run();
    end
endmodule